// File: doc/BRIEF.md
# Reed-Solomon Four-Parity Systematic Encoder

This block encodes a stream of 8-bit symbols over GF(2^8) into systematic Reed-Solomon codewords that carry four check symbols. A block of `DATA_LEN` data symbols enters on a valid/ready byte interface. Each data symbol is forwarded to the output one cycle after it is accepted. Once the last data symbol of the block has been taken, the input stalls for four cycles while the encoder emits the four remainder symbols. The same RTL builds a 24-to-28 encoder or a 28-to-32 encoder, chosen by the `DATA_LEN` parameter.

The generator polynomial is palindromic and of degree four: x^4 + g1·x^3 + g2·x^2 + g1·x + 1. The two coefficients g1 and g2 come from configuration inputs. Because g1 is shared between two taps, the feedback path needs only two constant-coefficient multipliers. The field is reduced by x^8 + x^4 + x^3 + x^2 + 1. The multipliers are shift-and-reduce logic, so no tables are used. A start-of-block marker restarts the encoder at any point in a block.

Top module: `rs4_enc`

## Requirements
- R1: A data symbol accepted on a clock edge (`s_valid_i` and `s_ready_o` both high) appears on `m_data_o` after that edge, with `m_valid_o` high and `m_parity_o` low.
- R2: After the DATA_LEN-th data symbol, the four parity symbols follow on consecutive cycles. With the first data symbol as the highest-degree coefficient, the codeword is divisible by x^4 + g1·x^3 + g2·x^2 + g1·x + 1. The parity symbols are the remainder coefficients, and the x^3 coefficient is output first.
- R3: Let α = 0x02. Take s1 = α + α^-1 and s2 = α^2 + α^-2, and set g1 = s1 + s2 and g2 = s1·s2. Every codeword then evaluates to zero at α, α^-1, α^2 and α^-2.
- R4: `s_ready_o` is low for exactly four cycles after the DATA_LEN-th symbol is accepted. A symbol offered during those cycles is not taken. It becomes the first symbol of the next block.
- R5: `m_parity_o` is high on exactly the four parity symbols. `m_last_o` is high only on the fourth of them.
- R6: `cfg_g1_i` and `cfg_g2_i` are sampled on the first symbol of a block. Changing them during the block has no effect on that block's parity. The new values apply from the next block onward.
- R7: During and after reset, `s_ready_o` is high and `m_valid_o` is low.
- R8: `DATA_LEN` sets the block length. Both 24 and 28 produce correct codewords.
- R9: A symbol accepted with `s_sob_i` high, including one in the middle of a block, clears the parity state and starts a new block of DATA_LEN symbols. The first symbol after reset is treated as a block start even without the marker.
- R10: In a cycle where no symbol is accepted and no parity is pending, `m_valid_o` is low on the next cycle. Idle gaps between data symbols do not change the parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_g1_i | input | 8 | Generator coefficient for the x and x^3 taps |
| cfg_g2_i | input | 8 | Generator coefficient for the x^2 tap |
| s_valid_i | input | 1 | Input symbol valid |
| s_ready_o | output | 1 | Encoder can accept a symbol |
| s_sob_i | input | 1 | Marks the first symbol of a block |
| s_data_i | input | 8 | Input data symbol |
| m_valid_o | output | 1 | Output symbol valid |
| m_data_o | output | 8 | Output symbol (data or parity) |
| m_parity_o | output | 1 | Output symbol is a parity symbol |
| m_last_o | output | 1 | Output symbol is the last of the codeword |

## Verification
A wrong value in any parity stage, a swapped tap coefficient or a wrong reduction mask stays hidden while data passes through. It surfaces in the four parity symbols at the end of the block, at most DATA_LEN+4 cycles after the fault. At that point both the long-division reference and the root evaluation disagree. A wrong symbol count or phase count shows sooner, in the stall pattern of `s_ready_o` and in the position of `m_last_o`. Latching the coefficients at the wrong moment, or clearing the registers at the wrong moment, only shows in blocks where the configuration or the start marker changes. For that reason those cases have directed tests.

// File: rtl/rs4_pkg.sv
package rs4_pkg;
  localparam int NPAR = 4;
  typedef enum logic {PH_DATA, PH_PAR} phase_e;
endpackage

// File: rtl/rs4_gf_mul.sv
module rs4_gf_mul #(
  parameter int SYM_W = 8,
  parameter logic [SYM_W-1:0] POLY_LO = 8'h1D
) (
  input  logic [SYM_W-1:0] a_i,
  input  logic [SYM_W-1:0] b_i,
  output logic [SYM_W-1:0] p_o
);
  logic [SYM_W-1:0] acc;
  logic [SYM_W-1:0] sh;

  always_comb begin
    acc = '0;
    sh  = a_i;
    for (int i = 0; i < SYM_W; i++) begin
      if (b_i[i]) acc = acc ^ sh;
      sh = {sh[SYM_W-2:0], 1'b0} ^ (sh[SYM_W-1] ? POLY_LO : '0);
    end
  end

  assign p_o = acc;
endmodule

// File: rtl/rs4_ctrl.sv
module rs4_ctrl
  import rs4_pkg::*;
#(
  parameter int DATA_LEN = 24
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic sob_i,
  output logic ready_o,
  output logic accept_o,
  output logic first_o,
  output logic shift_o,
  output logic last_o
);
  localparam int CNT_W = $clog2(DATA_LEN + 1);
  localparam int PC_W  = $clog2(NPAR);

  phase_e           ph_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic [PC_W-1:0]  pc_q;

  assign ready_o  = (ph_q == PH_DATA);
  assign accept_o = valid_i && ready_o;
  // block start: explicit marker or nothing counted yet
  assign first_o  = accept_o && (sob_i || cnt_q == '0);
  assign cnt_nxt  = first_o ? CNT_W'(1) : cnt_q + 1'b1;
  assign shift_o  = (ph_q == PH_PAR);
  assign last_o   = shift_o && (pc_q == PC_W'(NPAR - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_DATA;
      cnt_q <= '0;
      pc_q  <= '0;
    end else if (ph_q == PH_DATA) begin
      if (accept_o) begin
        if (cnt_nxt == CNT_W'(DATA_LEN)) begin
          ph_q  <= PH_PAR;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_nxt;
        end
      end
    end else begin
      if (last_o) begin
        ph_q <= PH_DATA;
        pc_q <= '0;
      end else begin
        pc_q <= pc_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rs4_coef.sv
module rs4_coef #(
  parameter int SYM_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [SYM_W-1:0] cfg_g1_i,
  input  logic [SYM_W-1:0] cfg_g2_i,
  output logic [SYM_W-1:0] g1_o,
  output logic [SYM_W-1:0] g2_o
);
  logic [SYM_W-1:0] g1_q, g2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      g1_q <= '0;
      g2_q <= '0;
    end else if (load_i) begin
      g1_q <= cfg_g1_i;
      g2_q <= cfg_g2_i;
    end
  end

  // first symbol of a block sees the live config, the rest see the latch
  assign g1_o = load_i ? cfg_g1_i : g1_q;
  assign g2_o = load_i ? cfg_g2_i : g2_q;
endmodule

// File: rtl/rs4_parity.sv
module rs4_parity
  import rs4_pkg::*;
#(
  parameter int SYM_W = 8,
  parameter logic [SYM_W-1:0] POLY_LO = 8'h1D
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             absorb_i,
  input  logic             clear_i,
  input  logic             shift_i,
  input  logic [SYM_W-1:0] d_i,
  input  logic [SYM_W-1:0] g1_i,
  input  logic [SYM_W-1:0] g2_i,
  output logic [SYM_W-1:0] top_o
);
  logic [SYM_W-1:0] p_q  [NPAR];
  logic [SYM_W-1:0] base [NPAR];
  logic [SYM_W-1:0] tap  [NPAR];
  logic [SYM_W-1:0] fb;
  logic [SYM_W-1:0] prod_g1, prod_g2;

  assign fb = d_i ^ (clear_i ? '0 : p_q[NPAR-1]);

  rs4_gf_mul #(.SYM_W(SYM_W), .POLY_LO(POLY_LO)) i_mul_g1 (
    .a_i(fb), .b_i(g1_i), .p_o(prod_g1)
  );
  rs4_gf_mul #(.SYM_W(SYM_W), .POLY_LO(POLY_LO)) i_mul_g2 (
    .a_i(fb), .b_i(g2_i), .p_o(prod_g2)
  );

  assign base[0] = '0;
  assign tap[0]  = fb;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       p_q[0] <= '0;
    else if (absorb_i) p_q[0] <= fb;
    else if (shift_i)  p_q[0] <= '0;
  end

  for (genvar j = 1; j < NPAR; j++) begin : g_stage
    assign base[j] = clear_i ? '0 : p_q[j-1];
    // palindromic taps: odd powers share g1, even power uses g2
    if (j % 2 == 1) begin : g_odd
      assign tap[j] = prod_g1;
    end else begin : g_even
      assign tap[j] = prod_g2;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       p_q[j] <= '0;
      else if (absorb_i) p_q[j] <= base[j] ^ tap[j];
      else if (shift_i)  p_q[j] <= p_q[j-1];
    end
  end

  assign top_o = p_q[NPAR-1];
endmodule

// File: rtl/rs4_enc.sv
module rs4_enc #(
  parameter int DATA_LEN = 24,
  parameter int SYM_W = 8,
  parameter logic [SYM_W-1:0] POLY_LO = 8'h1D
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SYM_W-1:0] cfg_g1_i,
  input  logic [SYM_W-1:0] cfg_g2_i,
  input  logic             s_valid_i,
  output logic             s_ready_o,
  input  logic             s_sob_i,
  input  logic [SYM_W-1:0] s_data_i,
  output logic             m_valid_o,
  output logic [SYM_W-1:0] m_data_o,
  output logic             m_parity_o,
  output logic             m_last_o
);
  logic             accept, first, shift, plast;
  logic [SYM_W-1:0] g1, g2, ptop;

  rs4_ctrl #(.DATA_LEN(DATA_LEN)) i_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(s_valid_i), .sob_i(s_sob_i),
    .ready_o(s_ready_o), .accept_o(accept), .first_o(first),
    .shift_o(shift), .last_o(plast)
  );

  rs4_coef #(.SYM_W(SYM_W)) i_coef (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(first),
    .cfg_g1_i(cfg_g1_i), .cfg_g2_i(cfg_g2_i), .g1_o(g1), .g2_o(g2)
  );

  rs4_parity #(.SYM_W(SYM_W), .POLY_LO(POLY_LO)) i_parity (
    .clk_i(clk_i), .rst_ni(rst_ni), .absorb_i(accept), .clear_i(first),
    .shift_i(shift), .d_i(s_data_i), .g1_i(g1), .g2_i(g2), .top_o(ptop)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_valid_o  <= 1'b0;
      m_data_o   <= '0;
      m_parity_o <= 1'b0;
      m_last_o   <= 1'b0;
    end else begin
      m_valid_o  <= accept || shift;
      m_parity_o <= shift;
      m_last_o   <= plast;
      if (accept)     m_data_o <= s_data_i;
      else if (shift) m_data_o <= ptop;
    end
  end
endmodule

// File: rtl/rs4_enc_chk.sv
module rs4_enc_chk #(
  parameter int SYM_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             s_valid_i,
  input logic             s_ready_o,
  input logic [SYM_W-1:0] s_data_i,
  input logic             m_valid_o,
  input logic [SYM_W-1:0] m_data_o,
  input logic             m_parity_o,
  input logic             m_last_o
);
  // R1
  passthru_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_valid_i && s_ready_o) |=> (m_valid_o && !m_parity_o && m_data_o == $past(s_data_i)));
  // R4
  stall_par_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !s_ready_o |=> (m_valid_o && m_parity_o));
  // R4
  ready_back_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_last_o |-> s_ready_o);
  // R5
  last_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_last_o |-> (m_valid_o && m_parity_o));
  // R5
  par_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_parity_o && !m_last_o) |=> m_parity_o);
  // R5
  last_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_last_o |=> !m_parity_o);
  // R10
  idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_ready_o && !s_valid_i) |=> !m_valid_o);
  // R7
  always_comb if (!rst_ni) reset_out_chk: assert (!m_valid_o && s_ready_o);
endmodule

bind rs4_enc rs4_enc_chk #(.SYM_W(SYM_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .s_valid_i(s_valid_i), .s_ready_o(s_ready_o),
  .s_data_i(s_data_i), .m_valid_o(m_valid_o), .m_data_o(m_data_o),
  .m_parity_o(m_parity_o), .m_last_o(m_last_o)
);

// File: tb/test_rs4_enc.sv
`timescale 1ns/1ps
module test_rs4_enc;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] g1_cfg [2];
  logic [7:0] g2_cfg [2];
  logic       s_valid [2];
  logic       s_sob [2];
  logic [7:0] s_data [2];
  logic       s_ready [2];
  logic       m_valid [2];
  logic [7:0] m_data [2];
  logic       m_par [2];
  logic       m_last [2];

  int n_chk = 0;
  int n_bad = 0;
  logic [9:0] cap [2][0:255];
  int cap_n [2];
  logic [7:0] blk [0:31];
  logic [7:0] rg1, rg2;

  always #5 clk_i = ~clk_i;

  rs4_enc #(.DATA_LEN(24)) i_rs4_enc (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_g1_i(g1_cfg[0]), .cfg_g2_i(g2_cfg[0]),
    .s_valid_i(s_valid[0]), .s_ready_o(s_ready[0]), .s_sob_i(s_sob[0]),
    .s_data_i(s_data[0]), .m_valid_o(m_valid[0]), .m_data_o(m_data[0]),
    .m_parity_o(m_par[0]), .m_last_o(m_last[0])
  );

  rs4_enc #(.DATA_LEN(28)) i_rs4_enc_k28 (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_g1_i(g1_cfg[1]), .cfg_g2_i(g2_cfg[1]),
    .s_valid_i(s_valid[1]), .s_ready_o(s_ready[1]), .s_sob_i(s_sob[1]),
    .s_data_i(s_data[1]), .m_valid_o(m_valid[1]), .m_data_o(m_data[1]),
    .m_parity_o(m_par[1]), .m_last_o(m_last[1])
  );

  always @(negedge clk_i) begin
    for (int s = 0; s < 2; s++) begin
      if (rst_ni && m_valid[s]) begin
        cap[s][cap_n[s] % 256] = {m_par[s], m_last[s], m_data[s]};
        cap_n[s] = cap_n[s] + 1;
      end
    end
  end

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r = 8'h00;
    logic [7:0] x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r ^= x;
      x = x[7] ? ((x << 1) ^ 8'h1D) : (x << 1);
    end
    return r;
  endfunction

  function automatic logic [7:0] gpow(input logic [7:0] a, input int e);
    logic [7:0] r = 8'h01;
    for (int i = 0; i < e; i++) r = gmul(r, a);
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic send(input int s, input logic [7:0] d, input logic sob, output int waits);
    s_valid[s] = 1'b1; s_data[s] = d; s_sob[s] = sob; waits = 0;
    while (!s_ready[s]) begin @(negedge clk_i); waits++; end
    @(negedge clk_i);
    s_valid[s] = 1'b0; s_sob[s] = 1'b0;
  endtask

  task automatic fill(input int kind, input int seed);
    for (int i = 0; i < 32; i++) begin
      case (kind)
        0: blk[i] = 8'h00;
        1: blk[i] = 8'(i + 1);
        2: blk[i] = 8'hFF;
        default: blk[i] = 8'(i * 37 + 11 + seed * 53);
      endcase
    end
  endtask

  task automatic send_block(input int s, input int k, input bit sob, input int gap);
    int w;
    for (int i = 0; i < k; i++) begin
      send(s, blk[i], sob && i == 0, w);
      if (gap > 0 && i % gap == gap - 1) repeat (2) @(negedge clk_i);
    end
  endtask

  // compare one captured codeword against long division by g(x)
  task automatic check_cw(input int s, input int base, input int k, input logic [7:0] g1,
                          input logic [7:0] g2, input bit roots, input string req);
    logic [7:0] m [0:35];
    logic [9:0] expw, got;
    logic [7:0] rt [4];
    logic [7:0] acc;
    for (int i = 0; i < 36; i++) m[i] = (i < k) ? blk[i] : 8'h00;
    for (int i = 0; i < k; i++) begin
      logic [7:0] c = m[i];
      m[i+1] ^= gmul(c, g1);
      m[i+2] ^= gmul(c, g2);
      m[i+3] ^= gmul(c, g1);
      m[i+4] ^= c;
    end
    for (int j = 0; j < k + 4; j++) begin
      got  = cap[s][(base + j) % 256];
      expw = {j >= k, j == k + 3, (j < k) ? blk[j] : m[j]};
      chk(got == expw, req, int'(got), int'(expw));
    end
    if (roots) begin
      rt[0] = 8'h02; rt[1] = gpow(8'h02, 254); rt[2] = 8'h04; rt[3] = gpow(8'h02, 253);
      for (int r = 0; r < 4; r++) begin
        acc = 8'h00;
        for (int j = 0; j < k + 4; j++) acc = gmul(acc, rt[r]) ^ cap[s][(base + j) % 256][7:0];
        chk(acc == 8'h00, "R3 root evaluation", int'(acc), 0);
      end
    end
  endtask

  task automatic t_reset;
    // R7
    chk(s_ready[0] && s_ready[1], "R7 ready after reset", int'(s_ready[0]), 1);
    chk(!m_valid[0] && !m_valid[1], "R7 no output after reset", int'(m_valid[0]), 0);
  endtask

  task automatic t_k24_patterns;
    // R1 R2 R3 R5: back-to-back blocks
    for (int p = 0; p < 4; p++) begin
      int base = cap_n[0];
      fill(p, p);
      send_block(0, 24, 1'b1, 0);
      repeat (6) @(negedge clk_i);
      check_cw(0, base, 24, rg1, rg2, 1'b1, "R2 k24 codeword");
      chk(cap_n[0] - base == 28, "R5 k24 symbol count", cap_n[0] - base, 28);
    end
  endtask

  task automatic t_k28_patterns;
    // R8 R9: first block without marker, then with
    for (int p = 1; p < 4; p++) begin
      int base = cap_n[1];
      fill(p, p + 5);
      send_block(1, 28, p != 1, 0);
      repeat (6) @(negedge clk_i);
      check_cw(1, base, 28, rg1, rg2, 1'b1, "R8 k28 codeword");
    end
  endtask

  task automatic t_gaps_stall;
    int w, base_a, base_b;
    // R10 R4
    base_a = cap_n[0];
    fill(3, 9);
    send_block(0, 24, 1'b1, 5);
    fill(3, 10);
    base_b = base_a + 28;
    send(0, blk[0], 1'b1, w);
    chk(w == 4, "R4 ready low cycles", w, 4);
    for (int i = 1; i < 24; i++) send(0, blk[i], 1'b0, w);
    repeat (6) @(negedge clk_i);
    check_cw(0, base_b, 24, rg1, rg2, 1'b1, "R4 held symbol starts next block");
    fill(3, 9);
    check_cw(0, base_a, 24, rg1, rg2, 1'b1, "R10 gapped block");
  endtask

  task automatic t_cfg_latch;
    int base, w;
    // R6
    g1_cfg[0] = 8'h37; g2_cfg[0] = 8'h5A;
    base = cap_n[0];
    fill(3, 21);
    for (int i = 0; i < 24; i++) begin
      if (i == 10) begin g1_cfg[0] = 8'hC3; g2_cfg[0] = 8'h01; end
      send(0, blk[i], i == 0, w);
    end
    repeat (6) @(negedge clk_i);
    check_cw(0, base, 24, 8'h37, 8'h5A, 1'b0, "R6 mid-block config change ignored");
    base = cap_n[0];
    send_block(0, 24, 1'b1, 0);
    repeat (6) @(negedge clk_i);
    check_cw(0, base, 24, 8'hC3, 8'h01, 1'b0, "R6 new config on next block");
    g1_cfg[0] = rg1; g2_cfg[0] = rg2;
  endtask

  task automatic t_sob_restart;
    int base;
    // R9
    base = cap_n[0];
    fill(2, 0);
    send_block(0, 7, 1'b1, 0);
    fill(3, 33);
    send_block(0, 24, 1'b1, 0);
    repeat (6) @(negedge clk_i);
    chk(cap_n[0] - base == 35, "R9 restart symbol count", cap_n[0] - base, 35);
    check_cw(0, base + 7, 24, rg1, rg2, 1'b1, "R9 restart codeword");
  endtask

  initial begin
    logic [7:0] s1, s2;
    s1 = 8'h02 ^ gpow(8'h02, 254);
    s2 = 8'h04 ^ gpow(8'h02, 253);
    rg1 = s1 ^ s2;
    rg2 = gmul(s1, s2);
    for (int s = 0; s < 2; s++) begin
      g1_cfg[s] = rg1; g2_cfg[s] = rg2;
      s_valid[s] = 1'b0; s_sob[s] = 1'b0; s_data[s] = 8'h00; cap_n[s] = 0;
    end
    repeat (3) @(negedge clk_i);
    t_reset;
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_k24_patterns;
    t_k28_patterns;
    t_gaps_stall;
    t_cfg_latch;
    t_sob_restart;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule